// File: doc/BRIEF.md
# Strip Readout and Noise-Scan Sequencer

This block is the central sequencer for a daisy chain of strip front-end boards. When a final trigger reaches it while it is idle, it raises a latch strobe that goes to every front-end at once, so that each board freezes its strip states. It then issues one load pulse and runs a divided shift clock. The shift clock moves a programmed number of bits out of the chain into the readout module. A one-cycle completion pulse closes each event.

Between events the same block runs a noise-scan timer. Each time a programmable window expires, it emits a window-end pulse and steps a 5-bit channel select to the next strip, wrapping after 32 channels. An external scaler uses the select and the pulse to count each strip's noise for one window. The scan pauses while bits are being shifted out, and the interrupted window starts again in full afterwards.

Top module: `evmon_seq`

## Requirements
- R1: During and directly after synchronous reset, `latch_o`, `load_o`, `busy_o`, `done_o`, `sclk_o` and `win_end_o` are low and `mon_sel_o` is 0.
- R2: A trigger sampled while idle raises `latch_o` for exactly 2 cycles, starting in the cycle after the trigger. `load_o` is high for exactly 1 cycle immediately after the latch strobe.
- R3: For a length N>0 and divider D, the shift clock has a half period of D+1 cycles and a 50% duty. It starts low, first goes high D+1 cycles after the load cycle, produces exactly N high phases, and is low whenever no shift is in progress.
- R4: A length of 0 produces no shift-clock pulse, and the transfer completes directly after the load cycle.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last falling shift-clock edge. `busy_o` is high for exactly 4 + 2·N·(D+1) cycles per event, from the cycle after the trigger to the `done_o` cycle inclusive.
- R6: A trigger that arrives while `busy_o` is high is dropped: it neither lengthens the event nor starts a second one.
- R7: While no shift is in progress, `win_end_o` pulses once every P cycles, where P is the programmed period and a period of 0 acts as 1. In the same cycle as the pulse, `mon_sel_o` has advanced by one modulo 32. `mon_sel_o` changes at no other time.
- R8: While the shift clock runs, the scan is frozen: there is no `win_end_o` and no change of `mon_sel_o`. The window is then restarted, so the next `win_end_o` comes exactly P cycles after the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Final trigger, sampled every cycle |
| cfg_div_i | input | 8 | Shift-clock divider D; half period is D+1 cycles |
| cfg_len_i | input | 12 | Bits per transfer N, captured in the load cycle |
| cfg_period_i | input | 24 | Noise-scan window length P in cycles |
| latch_o | output | 1 | Broadcast latch strobe to all front-ends |
| load_o | output | 1 | Parallel-load pulse to the chain |
| sclk_o | output | 1 | Divided shift clock to the chain |
| busy_o | output | 1 | High in every state except idle |
| done_o | output | 1 | One-cycle end-of-transfer pulse to the readout side |
| mon_sel_o | output | 5 | Strip channel currently under noise scan |
| win_end_o | output | 1 | One-cycle end-of-window pulse |

## Verification
A corrupted bit counter or phase counter in the transfer path appears in the event it occurs. It shows as a wrong number of shift-clock high phases or a misplaced first edge, and in any case as a `busy_o` length off the 4 + 2·N·(D+1) formula, visible at `done_o` within that transfer. A faulty window counter or pause condition shows within one period as a wrong spacing of `win_end_o`, or as a pulse during a transfer. A bad channel step shows at the next pulse as a select that did not move by exactly one. The sweeps cover every divider from 0 to 3 against lengths 0 to 4, several periods including 0 and 1, a full wrap of the 32 channels, and triggers held high through a whole event.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    // Transfer sequence states; order matters only for readability.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } xfer_st_e;

    // Control flags carried from the transfer FSM to the top.
    typedef struct packed {
        logic latch;
        logic load;
        logic shift;
        logic done;
        logic busy;
    } xfer_ctl_t;

    localparam int unsigned LATCH_CYCLES = 2;
    localparam int unsigned LC_W         = (LATCH_CYCLES > 1) ? $clog2(LATCH_CYCLES) : 1;

    function automatic xfer_ctl_t decode_ctl(xfer_st_e s);
        xfer_ctl_t c;
        c.latch = (s == ST_LATCH);
        c.load  = (s == ST_LOAD);
        c.shift = (s == ST_SHIFT);
        c.done  = (s == ST_DONE);
        c.busy  = (s != ST_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/evmon_sclk.sv
module evmon_sclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] phase_q;
    logic             sclk_q;
    logic             wrap;

    assign wrap = (phase_q == div_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_q <= '0;
            sclk_q  <= 1'b0;
        end else if (wrap) begin
            phase_q <= '0;
            sclk_q  <= ~sclk_q;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    // Asserted in the cycle whose closing edge drives the clock low.
    assign fall_o = run_i && sclk_q && wrap;

endmodule

// File: rtl/evmon_xfer.sv
module evmon_xfer
    import evmon_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             fall_i,
    output xfer_ctl_t        ctl_o
);
    xfer_st_e         st_q;
    logic [LC_W-1:0]  lcnt_q;
    logic [LEN_W-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            lcnt_q <= '0;
            bits_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (trig_i) begin
                        st_q   <= ST_LATCH;
                        lcnt_q <= '0;
                    end
                end
                ST_LATCH: begin
                    if (lcnt_q == LC_W'(LATCH_CYCLES - 1)) st_q <= ST_LOAD;
                    else lcnt_q <= lcnt_q + 1'b1;
                end
                ST_LOAD: begin
                    bits_q <= len_i;
                    st_q   <= (len_i == '0) ? ST_DONE : ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (fall_i) begin
                        bits_q <= bits_q - 1'b1;
                        if (bits_q == LEN_W'(1)) st_q <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl_o = decode_ctl(st_q);

endmodule

// File: rtl/evmon_mon.sv
module evmon_mon #(
    parameter int PER_W = 24,
    parameter int CH_N  = 32,
    localparam int CH_W = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pause_i,
    input  logic [PER_W-1:0] period_i,
    output logic [CH_W-1:0]  sel_o,
    output logic             win_o
);
    logic [PER_W-1:0] pcnt_q;
    logic [PER_W-1:0] last;
    logic [CH_W-1:0]  sel_q;
    logic             win_q;

    assign last = (period_i == '0) ? '0 : period_i - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            sel_q  <= '0;
            win_q  <= 1'b0;
        end else begin
            win_q <= 1'b0;
            if (pause_i) begin
                pcnt_q <= '0;
            end else if (pcnt_q >= last) begin
                pcnt_q <= '0;
                win_q  <= 1'b1;
                sel_q  <= (sel_q == CH_W'(CH_N - 1)) ? '0 : sel_q + 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    assign sel_o = sel_q;
    assign win_o = win_q;

endmodule

// File: rtl/evmon_seq.sv
module evmon_seq
    import evmon_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 12,
    parameter int PER_W = 24,
    parameter int CH_N  = 32,
    localparam int CH_W = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic [PER_W-1:0] cfg_period_i,
    output logic             latch_o,
    output logic             load_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CH_W-1:0]  mon_sel_o,
    output logic             win_end_o
);
    xfer_ctl_t ctl;
    logic      fall;
    logic      shift_run;

    assign shift_run = ctl.shift;

    evmon_xfer #(.LEN_W(LEN_W)) u_xfer (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .len_i  (cfg_len_i),
        .fall_i (fall),
        .ctl_o  (ctl)
    );

    evmon_sclk #(.DIV_W(DIV_W)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .run_i  (shift_run),
        .div_i  (cfg_div_i),
        .sclk_o (sclk_o),
        .fall_o (fall)
    );

    evmon_mon #(.PER_W(PER_W), .CH_N(CH_N)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .pause_i  (shift_run),
        .period_i (cfg_period_i),
        .sel_o    (mon_sel_o),
        .win_o    (win_end_o)
    );

    assign latch_o = ctl.latch;
    assign load_o  = ctl.load;
    assign busy_o  = ctl.busy;
    assign done_o  = ctl.done;

endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
    parameter int CH_N = 32,
    localparam int CH_W = $clog2(CH_N)
) (
    input logic            clk,
    input logic            rst,
    input logic            latch_o,
    input logic            load_o,
    input logic            sclk_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            win_end_o,
    input logic [CH_W-1:0] mon_sel_o,
    input logic            in_shift_i
);
    p_latch_pair_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_o) |=> latch_o && !load_o);

    p_load_after_latch_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_o) |-> load_o && busy_o);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    p_sclk_only_shift_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk_o) |-> $past(in_shift_i));

    p_no_win_paused_r8: assert property (@(posedge clk) disable iff (rst)
        $past(in_shift_i) |-> !win_end_o);

    p_sel_step_r7: assert property (@(posedge clk) disable iff (rst)
        win_end_o |-> mon_sel_o == (($past(mon_sel_o) == CH_W'(CH_N - 1)) ?
                                    CH_W'(0) : $past(mon_sel_o) + CH_W'(1)));

    p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !win_end_o |-> $stable(mon_sel_o));

endmodule

bind evmon_seq evmon_chk #(.CH_N(CH_N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .latch_o    (latch_o),
    .load_o     (load_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .win_end_o  (win_end_o),
    .mon_sel_o  (mon_sel_o),
    .in_shift_i (shift_run)
);

// File: tb/tb_evmon_seq.sv
module tb_evmon_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic [11:0] cfg_len = '0;
    logic [23:0] cfg_period = 24'd1000;
    logic        latch_o, load_o, sclk_o, busy_o, done_o, win_end_o;
    logic [4:0]  mon_sel_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    evmon_seq dut (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (trig),
        .cfg_div_i    (cfg_div),
        .cfg_len_i    (cfg_len),
        .cfg_period_i (cfg_period),
        .latch_o      (latch_o),
        .load_o       (load_o),
        .sclk_o       (sclk_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .mon_sel_o    (mon_sel_o),
        .win_end_o    (win_end_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One event; hold = keep trigger high during the whole event.
    task automatic do_xfer(input int d, input int n, input bit hold);
        int cyc = 0, nlatch = 0, nload = 0, ndone = 0, nhigh = 0, nrise = 0;
        int load_at = -1, first_hi = -1, done_at = -1, sclk_at_done = 0;
        logic prev = 1'b0;
        @(negedge clk);
        cfg_div = 8'(d);
        cfg_len = 12'(n);
        trig = 1'b1;
        @(negedge clk);
        trig = hold;
        while (busy_o && cyc < 5000) begin
            if (latch_o) begin
                nlatch++;
                if (cyc > 1) chk("R2 latch position", cyc, 1);
            end
            if (load_o) begin nload++; load_at = cyc; end
            if (sclk_o) begin
                nhigh++;
                if (first_hi < 0) first_hi = cyc;
            end
            if (sclk_o && !prev) nrise++;
            if (done_o) begin ndone++; done_at = cyc; sclk_at_done = sclk_o; end
            prev = sclk_o;
            @(negedge clk);
            cyc++;
        end
        trig = 1'b0;
        chk("R2 latch cycles", nlatch, 2);
        chk("R2 load cycles", nload, 1);
        chk("R2 load position", load_at, 2);
        chk("R5 busy cycles", cyc, 4 + 2 * n * (d + 1));
        chk("R5 done pulses", ndone, 1);
        chk("R5 done is last busy cycle", done_at, cyc - 1);
        chk("R3 sclk low at done", sclk_at_done, 0);
        if (n == 0) begin
            chk("R4 no shift pulses", nrise, 0);
        end else begin
            chk("R3 rising edges", nrise, n);
            chk("R3 high cycles", nhigh, n * (d + 1));
            chk("R3 first high cycle", first_hi, d + 4);
        end
        @(negedge clk);
        @(negedge clk);
        if (hold) chk("R6 no retrigger after held trigger", busy_o, 0);
    endtask

    task automatic mon_run(input int p, input int nwin);
        int w = 0, prev_sel, cnt;
        @(negedge clk);
        cfg_period = 24'(p);
        while (!win_end_o && w < 100000) begin @(negedge clk); w++; end
        prev_sel = mon_sel_o;
        for (int k = 0; k < nwin; k++) begin
            cnt = 0;
            do begin @(negedge clk); cnt++; end
            while (!win_end_o && cnt < 2 * p + 10);
            chk("R7 window spacing", cnt, (p == 0) ? 1 : p);
            chk("R7 select step", mon_sel_o, (prev_sel + 1) % 32);
            prev_sel = mon_sel_o;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int s0, n, sawwin, selchg, cnt;
        repeat (3) @(negedge clk);
        chk("R1 latch in reset", latch_o, 0);
        chk("R1 busy in reset", busy_o, 0);
        rst = 1'b0;
        chk("R1 load", load_o, 0);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 win_end", win_end_o, 0);
        chk("R1 select", mon_sel_o, 0);

        for (int d = 0; d < 4; d++)
            for (int len = 0; len < 5; len++)
                do_xfer(d, len, 1'b0);
        do_xfer(2, 3, 1'b1);   // R6
        do_xfer(0, 1, 1'b1);   // R6

        mon_run(1, 40);        // R7 with full wrap of the select
        mon_run(0, 5);
        mon_run(2, 6);
        mon_run(3, 5);
        mon_run(7, 4);

        // R8: pause during shifting and full window restart
        @(negedge clk);
        cfg_period = 24'd20;
        n = 0;
        while (!win_end_o && n < 100) begin @(negedge clk); n++; end
        s0 = mon_sel_o;
        cfg_div = 8'd1;
        cfg_len = 12'd3;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        n = 0; sawwin = 0; selchg = 0;
        while (!done_o && n < 1000) begin
            if (win_end_o) sawwin++;
            if (mon_sel_o != 5'(s0)) selchg++;
            @(negedge clk);
            n++;
        end
        chk("R8 no window end during event", sawwin, 0);
        chk("R8 select frozen during event", selchg, 0);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!win_end_o && cnt < 100);
        chk("R8 restarted window length", cnt, 20);
        chk("R8 select step after restart", mon_sel_o, (s0 + 1) % 32);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule